// File: doc/BRIEF.md
# Attribute Index/Data Port

This block is a register port where one bus address carries both a register index and register data. An internal toggle bit decides what a write to that address means. When the toggle is clear, the write loads a 6-bit index. When it is set, the write stores data into one of 21 eight-bit attribute registers, chosen by the low five bits of that index. Every write to the shared address inverts the toggle. Software puts the toggle into a known state by pulsing a separate status-read strobe, which clears it.

A second address reads the selected attribute register without touching the toggle. Each attribute register has a write mask, so its reserved bits always read back as zero. Reads are registered: the read data appears one clock after the read strobe and holds until the next read. The block stops at register storage and readback; it does not interpret the attribute values.

Top module: `attr_port`

## Requirements
- R1: After a synchronous active-high reset, the toggle, the index and all 21 attribute registers are zero, and `rdata_o` is zero.
- R2: A write to the shared address (`addr_i` = 0) while the toggle is 0 loads the index with `wdata_i[5:0]`.
- R3: A write to the shared address while the toggle is 1 stores data into the attribute register numbered by index bits [4:0]. Index bit 5 plays no part in the selection.
- R4: The toggle inverts after every write to the shared address, whether that write loaded the index or stored data.
- R5: Attribute registers 0x00 to 0x0F keep only bits [5:0] of the written data; bits [7:6] read as zero.
- R6: Register 0x10 stores the data with bit 4 forced to 0. Register 0x11 stores all 8 bits. Register 0x12 forces bits [7:6] to 0. Registers 0x13 and 0x14 force bits [7:4] to 0.
- R7: When index bits [4:0] are 0x15 or higher, a data write changes no register, and a read of the data address returns 0.
- R8: A read of the shared address returns the index, zero-extended to 8 bits, when the toggle is 0. It returns 0 when the toggle is 1.
- R9: `stat_rd_i` clears the toggle to 0. When it arrives in the same cycle as a shared-address write, the toggle ends at 0, but the write is still decoded as an index load or a data store according to the toggle's value before that edge.
- R10: A read of the data address (`addr_i` = 1) returns the register selected by index bits [4:0] and leaves the toggle unchanged. A write to the data address changes nothing.
- R11: Read data is registered. The value for a read strobed in one cycle appears on `rdata_o` after the next rising edge and reflects state from before any write in that same cycle. `rdata_o` holds its value in cycles without a read.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| addr_i | input | 1 | 0 = shared index/data address, 1 = data read address |
| wr_en_i | input | 1 | Write strobe |
| rd_en_i | input | 1 | Read strobe |
| stat_rd_i | input | 1 | Status-read strobe; clears the toggle |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Registered read data |

## Verification
Each state change (index load, register store, toggle flip or clear) takes effect at the rising edge that samples the strobe. A read strobed in the same cycle still returns the earlier state. The bench drives one operation per cycle at the falling edge and computes the expected read value from its model before applying that operation's effects to the model. A quarter period after the next rising edge, it compares `rdata_o` against that expected value. Because the bench compares in every cycle, including cycles without a read, it also checks that the output holds between reads.

// File: rtl/attr_port_pkg.sv
package attr_port_pkg;

  localparam int ATTR_DATA_W   = 8;
  localparam int ATTR_IDX_W    = 6;
  localparam int ATTR_SEL_W    = 5;
  localparam int ATTR_NUM_REGS = 21;

  typedef enum logic {
    PORT_SHARED = 1'b0,
    PORT_DATA   = 1'b1
  } port_sel_e;

  // Bits that survive a store into the register with the given number.
  function automatic logic [ATTR_DATA_W-1:0] store_mask(input int unsigned num);
    logic [ATTR_DATA_W-1:0] m;
    if (num < 16)       m = 8'h3F;
    else if (num == 16) m = 8'hEF;
    else if (num == 17) m = 8'hFF;
    else if (num == 18) m = 8'h3F;
    else if (num <= 20) m = 8'h0F;
    else                m = 8'h00;
    return m;
  endfunction

endpackage

// File: rtl/attr_seq_ctl.sv
module attr_seq_ctl #(
  parameter int IDX_W = 6
) (
  input  logic             clk_i,
  input  logic             rst_i,
  input  logic             shared_wr_i,
  input  logic             stat_clr_i,
  input  logic [IDX_W-1:0] wdata_i,
  output logic             toggle_o,
  output logic [IDX_W-1:0] idx_o,
  output logic             data_we_o
);

  logic             toggle_q;
  logic [IDX_W-1:0] idx_q;

  // The write is decoded by the toggle value before the edge.
  assign data_we_o = shared_wr_i & toggle_q;

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      toggle_q <= 1'b0;
      idx_q    <= '0;
    end else begin
      if (shared_wr_i && !toggle_q) begin
        idx_q <= wdata_i;
      end
      if (stat_clr_i) begin
        toggle_q <= 1'b0;
      end else if (shared_wr_i) begin
        toggle_q <= ~toggle_q;
      end
    end
  end

  assign toggle_o = toggle_q;
  assign idx_o    = idx_q;

endmodule

// File: rtl/attr_reg_bank.sv
module attr_reg_bank
  import attr_port_pkg::*;
#(
  parameter int NUM_REGS = 21,
  parameter int DATA_W   = 8,
  parameter int SEL_W    = 5
) (
  input  logic                             clk_i,
  input  logic                             rst_i,
  input  logic                             we_i,
  input  logic [SEL_W-1:0]                 sel_i,
  input  logic [DATA_W-1:0]                wdata_i,
  output logic [NUM_REGS-1:0][DATA_W-1:0]  regs_o
);

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
    localparam logic [DATA_W-1:0] MASK = DATA_W'(store_mask(g));
    logic [DATA_W-1:0] val_q;

    always_ff @(posedge clk_i) begin
      if (rst_i) begin
        val_q <= '0;
      end else if (we_i && (sel_i == SEL_W'(g))) begin
        val_q <= wdata_i & MASK;
      end
    end

    assign regs_o[g] = val_q;
  end

endmodule

// File: rtl/attr_read_path.sv
module attr_read_path
  import attr_port_pkg::*;
#(
  parameter int NUM_REGS = 21,
  parameter int DATA_W   = 8,
  parameter int IDX_W    = 6,
  parameter int SEL_W    = 5
) (
  input  logic                            clk_i,
  input  logic                            rst_i,
  input  logic                            rd_en_i,
  input  logic                            addr_i,
  input  logic                            toggle_i,
  input  logic [IDX_W-1:0]                idx_i,
  input  logic [NUM_REGS-1:0][DATA_W-1:0] regs_i,
  output logic [DATA_W-1:0]               rdata_o
);

  localparam int PAD_W = DATA_W - IDX_W;

  logic [SEL_W-1:0]  sel;
  logic              in_range;
  logic [DATA_W-1:0] shared_val;
  logic [DATA_W-1:0] data_val;
  logic [DATA_W-1:0] rdata_q;

  assign sel      = idx_i[SEL_W-1:0];
  assign in_range = (int'(sel) < NUM_REGS);

  always_comb begin
    shared_val = toggle_i ? '0 : {{PAD_W{1'b0}}, idx_i};
    data_val   = '0;
    for (int k = 0; k < NUM_REGS; k++) begin
      if (in_range && (sel == SEL_W'(k))) begin
        data_val = regs_i[k];
      end
    end
  end

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      rdata_q <= '0;
    end else if (rd_en_i) begin
      rdata_q <= (port_sel_e'(addr_i) == PORT_SHARED) ? shared_val : data_val;
    end
  end

  assign rdata_o = rdata_q;

endmodule

// File: rtl/attr_port.sv
module attr_port
  import attr_port_pkg::*;
#(
  parameter int NUM_REGS = ATTR_NUM_REGS,
  parameter int DATA_W   = ATTR_DATA_W,
  parameter int IDX_W    = ATTR_IDX_W,
  parameter int SEL_W    = ATTR_SEL_W
) (
  input  logic              clk_i,
  input  logic              rst_i,
  input  logic              addr_i,
  input  logic              wr_en_i,
  input  logic              rd_en_i,
  input  logic              stat_rd_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o
);

  logic                            shared_wr;
  logic                            toggle;
  logic [IDX_W-1:0]                idx;
  logic                            data_we;
  logic [NUM_REGS-1:0][DATA_W-1:0] regs;

  assign shared_wr = wr_en_i && (port_sel_e'(addr_i) == PORT_SHARED);

  attr_seq_ctl #(.IDX_W(IDX_W)) u_ctl (
    .clk_i       (clk_i),
    .rst_i       (rst_i),
    .shared_wr_i (shared_wr),
    .stat_clr_i  (stat_rd_i),
    .wdata_i     (wdata_i[IDX_W-1:0]),
    .toggle_o    (toggle),
    .idx_o       (idx),
    .data_we_o   (data_we)
  );

  attr_reg_bank #(.NUM_REGS(NUM_REGS), .DATA_W(DATA_W), .SEL_W(SEL_W)) u_bank (
    .clk_i   (clk_i),
    .rst_i   (rst_i),
    .we_i    (data_we),
    .sel_i   (idx[SEL_W-1:0]),
    .wdata_i (wdata_i),
    .regs_o  (regs)
  );

  attr_read_path #(.NUM_REGS(NUM_REGS), .DATA_W(DATA_W), .IDX_W(IDX_W), .SEL_W(SEL_W)) u_rd (
    .clk_i    (clk_i),
    .rst_i    (rst_i),
    .rd_en_i  (rd_en_i),
    .addr_i   (addr_i),
    .toggle_i (toggle),
    .idx_i    (idx),
    .regs_i   (regs),
    .rdata_o  (rdata_o)
  );

endmodule

// File: rtl/attr_port_chk.sv
module attr_port_chk #(
  parameter int NUM_REGS = 21,
  parameter int DATA_W   = 8,
  parameter int IDX_W    = 6,
  parameter int SEL_W    = 5
) (
  input logic                            clk_i,
  input logic                            rst_i,
  input logic                            addr_i,
  input logic                            wr_en_i,
  input logic                            rd_en_i,
  input logic                            stat_rd_i,
  input logic [DATA_W-1:0]               wdata_i,
  input logic [DATA_W-1:0]               rdata_o,
  input logic                            toggle,
  input logic [IDX_W-1:0]                idx,
  input logic [NUM_REGS-1:0][DATA_W-1:0] regs
);

  p_idx_load_r2: assert property (@(posedge clk_i) disable iff (rst_i)
    (wr_en_i && !addr_i && !toggle) |=> (idx == $past(wdata_i[IDX_W-1:0])));

  p_toggle_flip_r4: assert property (@(posedge clk_i) disable iff (rst_i)
    (wr_en_i && !addr_i && !stat_rd_i) |=> (toggle != $past(toggle)));

  p_status_clear_r9: assert property (@(posedge clk_i) disable iff (rst_i)
    stat_rd_i |=> !toggle);

  p_data_read_keeps_r10: assert property (@(posedge clk_i) disable iff (rst_i)
    (!stat_rd_i && !(wr_en_i && !addr_i)) |=> $stable(toggle));

  p_shared_read_zero_r8: assert property (@(posedge clk_i) disable iff (rst_i)
    (rd_en_i && !addr_i && toggle) |=> (rdata_o == '0));

  p_oor_read_zero_r7: assert property (@(posedge clk_i) disable iff (rst_i)
    (rd_en_i && addr_i && (int'(idx[SEL_W-1:0]) >= NUM_REGS)) |=> (rdata_o == '0));

  p_rdata_hold_r11: assert property (@(posedge clk_i) disable iff (rst_i)
    !rd_en_i |=> $stable(rdata_o));

  for (genvar g = 0; g < 16; g++) begin : g_low_chk
    p_low_reserved_r5: assert property (@(posedge clk_i) disable iff (rst_i)
      regs[g][7:6] == 2'b00);
  end

  p_reserved_r6: assert property (@(posedge clk_i) disable iff (rst_i)
    (regs[16][4] == 1'b0) && (regs[18][7:6] == 2'b00) &&
    (regs[19][7:4] == 4'h0) && (regs[20][7:4] == 4'h0));

endmodule

bind attr_port attr_port_chk #(
  .NUM_REGS(NUM_REGS), .DATA_W(DATA_W), .IDX_W(IDX_W), .SEL_W(SEL_W)
) u_chk (
  .clk_i     (clk_i),
  .rst_i     (rst_i),
  .addr_i    (addr_i),
  .wr_en_i   (wr_en_i),
  .rd_en_i   (rd_en_i),
  .stat_rd_i (stat_rd_i),
  .wdata_i   (wdata_i),
  .rdata_o   (rdata_o),
  .toggle    (toggle),
  .idx       (idx),
  .regs      (regs)
);

// File: tb/attr_port_tb.sv
module attr_port_tb_top;

  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst;
  logic       addr;
  logic       wr_en;
  logic       rd_en;
  logic       stat_rd;
  logic [7:0] wdata;
  logic [7:0] rdata;

  int compared = 0;
  int mismatched = 0;
  bit finished = 0;

  // Bench model of the block state.
  logic       m_tog;
  logic [5:0] m_idx;
  logic [7:0] m_regs [21];
  logic [7:0] exp_rd;

  always #(CLK_PERIOD/2) clk = ~clk;

  attr_port dut_i (
    .clk_i     (clk),
    .rst_i     (rst),
    .addr_i    (addr),
    .wr_en_i   (wr_en),
    .rd_en_i   (rd_en),
    .stat_rd_i (stat_rd),
    .wdata_i   (wdata),
    .rdata_o   (rdata)
  );

  // Masks as listed in R5 and R6.
  function automatic logic [7:0] keep_bits(input int n);
    if (n <= 15) return 8'h3F;
    if (n == 16) return 8'hEF;
    if (n == 17) return 8'hFF;
    if (n == 18) return 8'h3F;
    return 8'h0F;
  endfunction

  function automatic logic [7:0] model_read(input logic a);
    int s;
    s = int'(m_idx[4:0]);
    if (!a) return m_tog ? 8'h00 : {2'b00, m_idx};
    if (s < 21) return m_regs[s];
    return 8'h00;
  endfunction

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: actual 0x%02h expected 0x%02h", tag, act, exp);
    end
  endtask

  task automatic cyc(input logic w, input logic r, input logic a, input logic st,
                     input logic [7:0] d, input string tag);
    int s;
    @(negedge clk);
    wr_en = w; rd_en = r; addr = a; stat_rd = st; wdata = d;
    if (r) exp_rd = model_read(a);
    if (w && !a) begin
      if (!m_tog) m_idx = d[5:0];
      else begin
        s = int'(m_idx[4:0]);
        if (s < 21) m_regs[s] = d & keep_bits(s);
      end
    end
    if (st) m_tog = 1'b0;
    else if (w && !a) m_tog = ~m_tog;
    @(posedge clk);
    #(CLK_PERIOD/4);
    check(tag, rdata, exp_rd);
  endtask

  task automatic set_reg(input logic [7:0] ix, input logic [7:0] d, input string tag);
    cyc(0, 0, 0, 1, 8'h00, tag);
    cyc(1, 0, 0, 0, ix, tag);
    cyc(1, 0, 0, 0, d, tag);
    cyc(0, 1, 1, 0, 8'h00, tag);
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    mismatched++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    void'($urandom(32'h5EED_0A77));
    rst = 1'b1; addr = 1'b0; wr_en = 1'b0; rd_en = 1'b0; stat_rd = 1'b0; wdata = 8'h00;
    m_tog = 1'b0; m_idx = '0; exp_rd = 8'h00;
    for (int i = 0; i < 21; i++) m_regs[i] = 8'h00;
    repeat (3) @(posedge clk);
    #(CLK_PERIOD/4);
    check("R1", rdata, 8'h00);
    @(negedge clk);
    rst = 1'b0;

    cyc(0, 1, 0, 0, 8'h00, "R1");
    cyc(0, 1, 1, 0, 8'h00, "R1");
    cyc(1, 0, 0, 0, 8'hFF, "R2");
    cyc(0, 1, 0, 0, 8'h00, "R8");
    cyc(0, 0, 0, 1, 8'h00, "R9");
    cyc(0, 1, 0, 0, 8'h00, "R2");

    // Toggle flips after index and after data writes.
    cyc(1, 0, 0, 0, 8'h02, "R4");
    cyc(0, 1, 0, 0, 8'h00, "R4");
    cyc(1, 0, 0, 0, 8'h2A, "R3");
    cyc(0, 1, 0, 0, 8'h00, "R4");
    cyc(0, 1, 1, 0, 8'h00, "R3");

    set_reg(8'h05, 8'hFF, "R5");
    set_reg(8'h0F, 8'hC1, "R5");
    for (int n = 16; n <= 20; n++) set_reg(8'(n), 8'hFF, "R6");
    set_reg(8'h15, 8'hAA, "R7");
    set_reg(8'h1F, 8'h55, "R7");
    set_reg(8'h25, 8'h3C, "R3");

    // Status read and data write in one cycle.
    cyc(0, 0, 0, 1, 8'h00, "R9");
    cyc(1, 0, 0, 0, 8'h11, "R9");
    cyc(1, 0, 0, 1, 8'h77, "R9");
    cyc(0, 1, 1, 0, 8'h00, "R9");
    cyc(0, 1, 0, 0, 8'h00, "R9");

    // Data-address reads and writes leave the toggle alone.
    cyc(1, 0, 0, 0, 8'h11, "R10");
    cyc(0, 1, 1, 0, 8'h00, "R10");
    cyc(1, 0, 1, 0, 8'h55, "R10");
    cyc(0, 1, 0, 0, 8'h00, "R10");
    cyc(1, 0, 0, 0, 8'h99, "R10");
    cyc(0, 1, 1, 0, 8'h00, "R10");
    cyc(0, 0, 0, 0, 8'h00, "R11");

    for (int t = 0; t < 4000; t++) begin
      cyc(1'($urandom % 2), 1'($urandom % 2), 1'(($urandom % 4) == 0),
          1'(($urandom % 8) == 0), 8'($urandom), "R11");
    end

    @(negedge clk);
    wr_en = 1'b0; rd_en = 1'b0; stat_rd = 1'b0;
    summary();
  end

endmodule